// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core

This block is a synthesizable behavioural model of a pipelined static RAM with a common data path. Every access moves exactly two 18-bit words. A single clock runs at twice the command rate, and an internal phase bit alternates between two edge types. The command edge stands for the rising edge of the main clock. The complement edge stands for the rising edge of the inverted clock. Load, direction and address are sampled only on command edges. Write data and the per-lane write masks are taken on both edge types.

A write that is accepted in one cycle takes its two data beats during the following cycle. Each beat is stored into the array in the same edge that captures it. A read returns its first word half a cycle into the next cycle and its second word on the command edge after that. A short-latency mode moves both words one phase earlier. The output enable and the data-valid strobe frame exactly those phases. The data output returns to zero whenever nothing is being driven.

Top module: `ddrb_core`

## Requirements
- R1: From reset until the first read, `dout_oe_o` and `dvld_o` are low and `dout_o` is zero. The first edge after reset is a command edge.
- R2: On a command edge where `ld_n_i` is high, the cycle is a no-op. Address, direction and the later data beats have no effect on the array or on the outputs. The load, direction and address inputs are ignored on complement edges.
- R3: The second word of a burst uses the start address with bit 0 inverted, and the upper bits are unchanged. A start at an odd address therefore accesses the odd word first and the even word second.
- R4: A write accepted on the command edge of cycle t takes its first beat on the command edge of cycle t+1 and its second beat on the complement edge of cycle t+1.
- R5: `bw_n_i` is active low, with one bit per lane. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. The mask is sampled separately with each beat. A mask of 2'b11 writes nothing for that beat.
- R6: With `lat_short_i` low, a read accepted in cycle t drives its first word from the complement edge of cycle t+1 and its second word from the command edge of cycle t+2.
- R7: When no read follows, the output enable and data-valid strobe fall 2.5 cycles after the read command edge, and `dout_o` returns to zero.
- R8: With `lat_short_i` high, the read latency is exactly one cycle: the first word comes on the command edge of cycle t+1 and the second on the next complement edge. The release comes two cycles after the command.
- R9: Commands may follow one another in consecutive cycles. Back-to-back reads keep the output enabled with no gap, and write bursts may follow reads directly.
- R10: A read accepted in the cycle right after a write to the same address returns the newly written lanes, merged with the stored data of any masked lanes.
- R11: `dvld_o` is high on exactly the phases where read data is being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; edges alternate command / complement |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_short_i | input | 1 | High selects the one-cycle read latency |
| ld_n_i | input | 1 | Active-low load strobe, sampled on command edges |
| rd_wn_i | input | 1 | High = read, low = write, when loaded |
| addr_i | input | ADDR_W (6) | Burst start address |
| bw_n_i | input | LANES (2) | Active-low per-lane write mask for the current beat |
| din_i | input | DATA_W (18) | Write data for the current beat |
| dout_o | output | DATA_W (18) | Read data, zero when released |
| dout_oe_o | output | 1 | Output drive enable |
| dvld_o | output | 1 | Echo data-valid strobe |

## Verification
The assertions assume that `lat_short_i` changes only while no read is in flight. They also assume that the inputs hold steady between edges, so that the value sampled two edges back is the value of the matching command edge. The bench changes the latency mode only after several idle cycles. It drives every input at the falling edge of the fast clock. On complement edges it deliberately drives an active load with a toggled direction and an inverted address, so that any sampling on the wrong phase shows up as a data or enable mismatch.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

endpackage

// File: rtl/ddrb_array.sv
module ddrb_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]         raddr_i,
    output logic [LANES*LANE_W-1:0]   rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per lane so each lane has its own write strobe.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                cells[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = cells[raddr_i];
    end
endmodule

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
    import ddrb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byp_i,
    input  logic                      ld_n_i,
    input  logic                      rd_wn_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES-1:0]          bw_n_i,
    input  logic [LANES*LANE_W-1:0]   din_i,
    output logic [LANES-1:0]          we_lane_o,
    output logic [ADDR_W-1:0]         waddr_o,
    output logic [LANES*LANE_W-1:0]   wdata_o,
    output logic [ADDR_W-1:0]         raddr_o,
    input  logic [LANES*LANE_W-1:0]   rdata_i,
    output logic [LANES*LANE_W-1:0]   dout_o,
    output logic                      oe_o,
    output logic                      dvld_o
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] a;
    } cmd_t;

    typedef struct packed {
        logic              ph;    // 0: next edge is a command edge
        cmd_t              c;     // command taken on the last command edge
        cmd_t              s;     // command taken one cycle earlier
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              vld;
    } st_t;

    st_t  st_q, st_d;
    logic rd_go;

    function automatic logic [ADDR_W-1:0] partner(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:1], ~a[0]};
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.ph   = ~st_q.ph;
        we_lane_o = '0;
        waddr_o   = '0;
        wdata_o   = din_i;
        raddr_o   = '0;
        rd_go     = 1'b0;
        if (!st_q.ph) begin
            // command edge: take a new command, age the previous one
            st_d.c.op = ld_n_i ? OP_NOP : (rd_wn_i ? OP_RD : OP_WR);
            st_d.c.a  = ld_n_i ? '0 : addr_i;
            st_d.s    = st_q.c;
            if (st_q.c.op == OP_WR) begin
                we_lane_o = ~bw_n_i;
                waddr_o   = st_q.c.a;
            end
            if (byp_i) begin
                rd_go   = (st_q.c.op == OP_RD);
                raddr_o = st_q.c.a;
            end else begin
                rd_go   = (st_q.s.op == OP_RD);
                raddr_o = partner(st_q.s.a);
            end
        end else begin
            // complement edge: second write beat, read word by mode
            if (st_q.s.op == OP_WR) begin
                we_lane_o = ~bw_n_i;
                waddr_o   = partner(st_q.s.a);
            end
            rd_go   = (st_q.s.op == OP_RD);
            raddr_o = byp_i ? partner(st_q.s.a) : st_q.s.a;
        end
        st_d.oe  = rd_go;
        st_d.vld = rd_go;
        st_d.dq  = rd_go ? rdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.dq;
    assign oe_o   = st_q.oe;
    assign dvld_o = st_q.vld;

    AST_NORM_FIRST_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_i && $stable(byp_i) && $rose(oe_o)) |-> !st_q.ph); // R6
    AST_SHORT_FIRST_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_i && $stable(byp_i) && $rose(oe_o)) |-> st_q.ph); // R8
    AST_TWO_BEAT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> $past(oe_o, 2)); // R7
    AST_WRITE_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ph && (we_lane_o != '0)) |-> $past(!ld_n_i && !rd_wn_i, 2)); // R4
    AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ph && $past(ld_n_i, 2)) |-> (we_lane_o == '0)); // R2
    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (dout_o == '0 && !dvld_o)); // R11
endmodule

// File: rtl/ddrb_core.sv
module ddrb_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_short_i,
    input  logic              ld_n_i,
    input  logic              rd_wn_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o,
    output logic              dvld_o
);
    logic [LANES-1:0]  we_lane;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    ddrb_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byp_i     (lat_short_i),
        .ld_n_i    (ld_n_i),
        .rd_wn_i   (rd_wn_i),
        .addr_i    (addr_i),
        .bw_n_i    (bw_n_i),
        .din_i     (din_i),
        .we_lane_o (we_lane),
        .waddr_o   (waddr),
        .wdata_o   (wdata),
        .raddr_o   (raddr),
        .rdata_i   (rdata),
        .dout_o    (dout_o),
        .oe_o      (dout_oe_o),
        .dvld_o    (dvld_o)
    );

    ddrb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we_i    (we_lane),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );
endmodule

// File: tb/tb_ddrb_core.sv
module tb_ddrb_core;
    localparam int OPN = 0;
    localparam int OPR = 1;
    localparam int OPW = 2;
    localparam int NE  = 1024;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  a;
        logic [1:0]  bw0;
        logic [17:0] d0;
        logic [1:0]  bw1;
        logic [17:0] d1;
        logic [3:0]  tag;
    } row_t;

    localparam int NROW = 21;
    localparam row_t TBL [NROW] = '{
        '{2'd2, 6'd0, 2'b00, 18'h00111, 2'b00, 18'h00222, 4'd4},  // R4 fill 0,1
        '{2'd2, 6'd2, 2'b00, 18'h00333, 2'b00, 18'h00444, 4'd4},  // R4 fill 2,3
        '{2'd2, 6'd5, 2'b00, 18'h00555, 2'b00, 18'h00666, 4'd3},  // R3 odd start: 5 then 4
        '{2'd2, 6'd6, 2'b00, 18'h00777, 2'b00, 18'h00888, 4'd4},  // R4 fill 6,7
        '{2'd0, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd7},
        '{2'd1, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd6},          // R6
        '{2'd0, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd7},          // R7 release
        '{2'd0, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd7},
        '{2'd1, 6'd1, 2'b11, 18'h0, 2'b11, 18'h0, 4'd3},          // R3 order 1,0
        '{2'd1, 6'd5, 2'b11, 18'h0, 2'b11, 18'h0, 4'd3},          // R3 back to back
        '{2'd1, 6'd2, 2'b11, 18'h0, 2'b11, 18'h0, 4'd9},          // R9 third read, no gap
        '{2'd2, 6'd2, 2'b10, 18'h3FFFF, 2'b01, 18'h2AAAA, 4'd5},  // R5 per-beat masks
        '{2'd1, 6'd2, 2'b11, 18'h0, 2'b11, 18'h0, 4'd10},         // R10 read right after
        '{2'd2, 6'd4, 2'b11, 18'h12345, 2'b11, 18'h00F0F, 4'd5},  // R5 write nothing
        '{2'd1, 6'd4, 2'b11, 18'h0, 2'b11, 18'h0, 4'd5},          // R5 unchanged
        '{2'd0, 6'd6, 2'b00, 18'h3FFFF, 2'b00, 18'h3FFFF, 4'd2},  // R2 no-op with data
        '{2'd1, 6'd6, 2'b11, 18'h0, 2'b11, 18'h0, 4'd2},          // R2 still old
        '{2'd2, 6'd7, 2'b00, 18'h0ABCD, 2'b00, 18'h1DCBA, 4'd9},  // R9 write after read
        '{2'd1, 6'd7, 2'b11, 18'h0, 2'b11, 18'h0, 4'd10},         // R10 odd start
        '{2'd0, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd7},
        '{2'd0, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lat_short;
    logic        ld_n;
    logic        rd_wn;
    logic [5:0]  addr;
    logic [1:0]  bw_n;
    logic [17:0] din;
    logic [17:0] dout;
    logic        dout_oe;
    logic        dvld;

    always #2 clk = ~clk;

    ddrb_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_short_i (lat_short),
        .ld_n_i      (ld_n),
        .rd_wn_i     (rd_wn),
        .addr_i      (addr),
        .bw_n_i      (bw_n),
        .din_i       (din),
        .dout_o      (dout),
        .dout_oe_o   (dout_oe),
        .dvld_o      (dvld)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [17:0] refm [64];
    bit          sv [NE];
    logic [5:0]  sa [NE];
    int          stag [NE];
    int          e = 0;
    bit          any_rd = 0;
    bit          exp_oe;
    logic [17:0] exp_d;
    int          exp_tag;
    int          p_op = OPN;
    logic [5:0]  p_a = '0;
    logic [1:0]  p_bw0 = 2'b11;
    logic [1:0]  p_bw1 = 2'b11;
    logic [17:0] p_d0 = '0;
    logic [17:0] p_d1 = '0;

    function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] d,
                                          input logic [1:0] bw);
        logic [17:0] r = o;
        if (!bw[0]) r[8:0] = d[8:0];
        if (!bw[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    function automatic logic [5:0] flip(input logic [5:0] a);
        return {a[5:1], ~a[0]};
    endfunction

    // expected output after edge e, taken before this edge's write lands
    task automatic expect_edge();
        exp_oe  = sv[e];
        exp_d   = sv[e] ? refm[sa[e]] : 18'h0;
        exp_tag = sv[e] ? stag[e] : (any_rd ? 7 : 1);
        if (sv[e]) any_rd = 1;
        sv[e] = 0;
    endtask

    task automatic check_phase();
        checks++;
        if (dout_oe !== exp_oe || dout !== exp_d) begin
            errors++;
            $display("FAIL R%0d edge %0d: oe=%b dout=%h expected oe=%b dout=%h",
                     exp_tag, e - 1, dout_oe, dout, exp_oe, exp_d);
        end
        checks++;
        if (dvld !== exp_oe) begin
            errors++;
            $display("FAIL R11 edge %0d: dvld=%b expected %b", e - 1, dvld, exp_oe);
        end
    endtask

    task automatic run_cycle(input int op, input logic [5:0] a, input logic [1:0] bw0,
                             input logic [17:0] d0, input logic [1:0] bw1,
                             input logic [17:0] d1, input int tag);
        ld_n  = (op == OPN);
        rd_wn = (op == OPR);
        addr  = a;
        bw_n  = p_bw0;
        din   = p_d0;
        @(posedge clk);
        expect_edge();
        if (p_op == OPW) refm[p_a] = merge(refm[p_a], p_d0, p_bw0);
        if (op == OPR) begin
            int f = lat_short ? e + 2 : e + 3;
            sv[f] = 1;     sa[f] = a;           stag[f] = tag;
            sv[f+1] = 1;   sa[f+1] = flip(a);   stag[f+1] = tag;
        end
        e++;
        @(negedge clk);
        check_phase();
        // complement phase: active-looking control that must be ignored (R2)
        ld_n  = 1'b0;
        rd_wn = ~rd_wn;
        addr  = ~a;
        bw_n  = p_bw1;
        din   = p_d1;
        @(posedge clk);
        expect_edge();
        if (p_op == OPW) refm[flip(p_a)] = merge(refm[flip(p_a)], p_d1, p_bw1);
        e++;
        @(negedge clk);
        check_phase();
        p_op = op; p_a = a; p_bw0 = bw0; p_d0 = d0; p_bw1 = bw1; p_d1 = d1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: run still busy, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) refm[i] = '0;
        for (int i = 0; i < NE; i++) sv[i] = 0;
        rst_n = 1'b0; lat_short = 1'b0; ld_n = 1'b1; rd_wn = 1'b0;
        addr = '0; bw_n = 2'b11; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_oe = 0; exp_d = '0; exp_tag = 1;
        check_phase();  // R1 in reset
        rst_n = 1'b1;

        // R1: idle cycles right after reset stay released
        run_cycle(OPN, 6'd9, 2'b00, 18'h3FFFF, 2'b00, 18'h3FFFF, 1);
        run_cycle(OPN, 6'd3, 2'b11, 18'h0, 2'b11, 18'h0, 1);

        for (int r = 0; r < NROW; r++) begin
            run_cycle(int'(TBL[r].op), TBL[r].a, TBL[r].bw0, TBL[r].d0,
                      TBL[r].bw1, TBL[r].d1, int'(TBL[r].tag));
        end

        // R8: one-cycle read latency, entered while idle
        lat_short = 1'b1;
        run_cycle(OPR, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 8);
        run_cycle(OPR, 6'd5, 2'b11, 18'h0, 2'b11, 18'h0, 8);
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 8);
        run_cycle(OPW, 6'd1, 2'b01, 18'h2BEEF, 2'b00, 18'h1CAFE, 8);
        run_cycle(OPR, 6'd1, 2'b11, 18'h0, 2'b11, 18'h0, 10);  // R10 in short mode
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 8);
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 8);
        lat_short = 1'b0;
        // R9: read, read, write, write in normal mode
        run_cycle(OPR, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 9);
        run_cycle(OPR, 6'd6, 2'b11, 18'h0, 2'b11, 18'h0, 9);
        run_cycle(OPW, 6'd3, 2'b00, 18'h13579, 2'b00, 18'h02468, 9);
        run_cycle(OPW, 6'd4, 2'b00, 18'h3C3C3, 2'b10, 18'h11111, 9);
        run_cycle(OPR, 6'd3, 2'b11, 18'h0, 2'b11, 18'h0, 9);
        run_cycle(OPR, 6'd4, 2'b11, 18'h0, 2'b11, 18'h0, 9);
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 7);
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 7);
        run_cycle(OPN, 6'd0, 2'b11, 18'h0, 2'b11, 18'h0, 7);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule